// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block sits between a small 8-bit controller core and its data storage. It turns each core access into a 12-bit data address and routes the access to the right storage. The 4096-byte data space is split into sixteen 256-byte banks. An address is formed in one of three ways. Banked accesses join a 4-bit bank register with the 8-bit operand. Window accesses map the operand onto a fixed 256-byte window that needs no bank register. Move operations carry full 12-bit source and destination addresses and ignore the bank register.

Only some banks hold storage. Banks 0, 1, 2 and 15 go to an external RAM port, which returns read data one cycle after the request. Bank 4 is a buffer built into the block. A USB engine shares this buffer through its own port. While the engine is enabled it owns the buffer: core writes to bank 4 are dropped and core reads of bank 4 return zero. While the engine is disabled, bank 4 is ordinary core storage. Any other bank is unimplemented: writes to it are dropped and reads from it return zero.

Core requests use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold the request steady while `req_ready` is low. `req_ready` drops for one cycle after a move is accepted, because the move's write uses that cycle. Read responses cannot be held off: `rsp_valid` is a one-cycle pulse that the core must take when it appears.

Top module: `banked_dmem_unit`

## Requirements
- R1: During and after reset, `bank_sel` is 0, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: A cycle with `bank_load` high stores `bank_imm[3:0]` as the bank number. `bank_sel` shows the stored number in bits 3:0, and bits 7:4 always read 0.
- R3: A read (`req_op`=00) or write (`req_op`=01) with `req_access`=0 addresses {bank number, `req_opnd`}.
- R4: With `req_access`=1, operands 0x00–0x5F address 0x000–0x05F and operands 0x60–0xFF address 0xF60–0xFFF, whatever the bank number is.
- R5: Addresses in banks 0, 1, 2 and 15 go to the mem port; reads return `mem_rdata` as sampled one cycle after the request. An address in any bank other than 0, 1, 2, 4 or 15 never raises `mem_req`; a read of it returns 0x00 and a write to it is dropped.
- R6: `rsp_valid` is high for exactly one cycle, the cycle after a read is accepted, and at no other time.
- R7: A move (`req_op`=10) reads `req_src` and, in the next cycle, writes that byte to `req_dst`. Both addresses are full 12-bit addresses; the bank number and `req_access` play no part. An unimplemented source yields 0x00, and a write to an unimplemented destination is dropped. A move gives no response.
- R8: `req_ready` is 0 in the cycle after a move is accepted. A request held during that cycle is accepted one cycle later.
- R9: While `usb_en`=0, bank 4 works as ordinary core read/write storage, and the USB port has no effect.
- R10: While `usb_en`=1, the USB port reads and writes the bank 4 buffer (`usb_rdata` is valid one cycle after a read). Core writes to bank 4 are dropped and core reads of bank 4 return 0x00. The buffer contents are the same ones the core sees when `usb_en`=0.
- R11: `req_op`=11 is accepted with no effect: no `mem_req`, no buffer change and no response.
- R12: A request accepted in the same cycle as a bank load uses the bank number held before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_load | input | 1 | Load the bank register from bank_imm |
| bank_imm | input | 8 | Immediate bank value; only bits 3:0 are kept |
| bank_sel | output | 8 | Current bank register, upper bits zero |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 00 read, 01 write, 10 move, 11 no-op |
| req_access | input | 1 | 1 selects the fixed window for read/write |
| req_opnd | input | 8 | Low-order operand address |
| req_wdata | input | 8 | Write data |
| req_src | input | 12 | Move source address |
| req_dst | input | 12 | Move destination address |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_data | output | 8 | Read data |
| usb_en | input | 1 | USB engine owns the bank 4 buffer |
| usb_valid | input | 1 | USB buffer access |
| usb_we | input | 1 | USB access is a write |
| usb_addr | input | 8 | USB buffer byte address |
| usb_wdata | input | 8 | USB write data |
| usb_rdata | output | 8 | USB read data, one cycle after the read |
| mem_req | output | 1 | External RAM access |
| mem_we | output | 1 | External RAM write |
| mem_addr | output | 12 | External RAM address |
| mem_wdata | output | 8 | External RAM write data |
| mem_rdata | input | 8 | External RAM read data, one cycle after the request |

## Verification
The hardest situation to reach is a contest over the bank 4 buffer. It needs ownership of the buffer to change hands between requests, a core write to bank 4 and a USB write landing in the same cycle, and a move whose source or destination is the buffer or an unimplemented bank. Directed sequences set up each of these cases: a simultaneous core/USB write, a move held off by back-pressure, and a bank load in the same cycle as a request. Seeded random traffic then toggles `usb_en` between core and USB operations over random banks, operands and moves. The results are compared against shadow models of the external RAM and the buffer. A monitor on the mem port flags any request to an address that is not backed by external RAM.

// File: rtl/bdm_pkg.sv
`timescale 1ns/1ps
package bdm_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_MOVE  = 2'd2,
    OP_NOP   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    TG_NONE = 2'd0,
    TG_MEM  = 2'd1,
    TG_BUF  = 2'd2
  } tgt_e;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_MOVE_WR = 1'b1
  } state_e;
endpackage

// File: rtl/bdm_bank_reg.sv
`timescale 1ns/1ps
module bdm_bank_reg #(
  parameter int BANK_W = 4,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IMM_W-1:0]  imm,
  output logic [BANK_W-1:0] bank,
  output logic [IMM_W-1:0]  bank_rd
);
  localparam int PAD_W = IMM_W - BANK_W;

  logic [BANK_W-1:0] bank_q;
  logic              unused_imm_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (load) begin
      bank_q <= imm[BANK_W-1:0];
    end
  end

  // Upper immediate bits are not stored.
  assign unused_imm_hi = ^imm[IMM_W-1:BANK_W];
  assign bank          = bank_q;
  assign bank_rd       = {{PAD_W{1'b0}}, bank_q};
endmodule

// File: rtl/bdm_addr_gen.sv
`timescale 1ns/1ps
module bdm_addr_gen #(
  parameter int                OPND_W      = 8,
  parameter int                BANK_W      = 4,
  parameter logic [OPND_W-1:0] ACC_SPLIT   = 8'h60,
  parameter logic [BANK_W-1:0] ACC_LO_BANK = 4'h0,
  parameter logic [BANK_W-1:0] ACC_HI_BANK = 4'hF
) (
  input  logic                     full_en,
  input  logic [BANK_W+OPND_W-1:0] full_addr,
  input  logic                     access,
  input  logic [OPND_W-1:0]        opnd,
  input  logic [BANK_W-1:0]        bank,
  output logic [BANK_W+OPND_W-1:0] addr
);
  logic [BANK_W-1:0] win_bank;

  // Window split: low operands stay in the low bank, the rest go to the top bank.
  assign win_bank = (opnd < ACC_SPLIT) ? ACC_LO_BANK : ACC_HI_BANK;

  always_comb begin
    if (full_en) begin
      addr = full_addr;
    end else if (access) begin
      addr = {win_bank, opnd};
    end else begin
      addr = {bank, opnd};
    end
  end
endmodule

// File: rtl/bdm_region_dec.sv
`timescale 1ns/1ps
module bdm_region_dec
  import bdm_pkg::*;
#(
  parameter int                       OPND_W    = 8,
  parameter int                       BANK_W    = 4,
  parameter logic [(1<<BANK_W)-1:0]   IMPL_MASK = 16'h8007,
  parameter int                       BUF_BANK  = 4
) (
  input  logic [BANK_W+OPND_W-1:0] addr,
  input  logic                     usb_en,
  output tgt_e                     tgt
);
  localparam int NB = 1 << BANK_W;
  localparam int AW = BANK_W + OPND_W;

  logic [NB-1:0]     mem_vec;
  logic [NB-1:0]     buf_vec;
  logic [BANK_W-1:0] bk;
  logic              unused_low;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign mem_vec[g] = IMPL_MASK[g] && (g != BUF_BANK);
    assign buf_vec[g] = (g == BUF_BANK);
  end

  assign bk         = addr[AW-1:OPND_W];
  assign unused_low = ^addr[OPND_W-1:0];

  always_comb begin
    if (buf_vec[bk]) begin
      tgt = usb_en ? TG_NONE : TG_BUF;
    end else if (mem_vec[bk]) begin
      tgt = TG_MEM;
    end else begin
      tgt = TG_NONE;
    end
  end
endmodule

// File: rtl/bdm_buf_ram.sv
`timescale 1ns/1ps
module bdm_buf_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              usb_en,
  input  logic              usb_valid,
  input  logic              usb_we,
  input  logic [ADDR_W-1:0] usb_addr,
  input  logic [DATA_W-1:0] usb_wdata,
  input  logic              core_en,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] arr [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              usb_go;
  logic              sel_en;
  logic              sel_we;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;

  // Fixed priority: the USB side wins whenever it owns the buffer and asks.
  assign usb_go    = usb_en && usb_valid;
  assign sel_en    = usb_go || core_en;
  assign sel_we    = usb_go ? usb_we    : core_we;
  assign sel_addr  = usb_go ? usb_addr  : core_addr;
  assign sel_wdata = usb_go ? usb_wdata : core_wdata;

  always_ff @(posedge clk) begin
    if (sel_en && sel_we) begin
      arr[sel_addr] <= sel_wdata;
    end
    if (sel_en && !sel_we) begin
      rd_q <= arr[sel_addr];
    end
  end

  assign rdata = rd_q;
endmodule

// File: rtl/banked_dmem_unit.sv
`timescale 1ns/1ps
module banked_dmem_unit
  import bdm_pkg::*;
#(
  parameter int                       DATA_W      = 8,
  parameter int                       OPND_W      = 8,
  parameter int                       BANK_W      = 4,
  parameter int                       IMM_W       = 8,
  parameter logic [(1<<BANK_W)-1:0]   IMPL_MASK   = 16'h8007,
  parameter int                       BUF_BANK    = 4,
  parameter logic [OPND_W-1:0]        ACC_SPLIT   = 8'h60,
  parameter logic [BANK_W-1:0]        ACC_LO_BANK = 4'h0,
  parameter logic [BANK_W-1:0]        ACC_HI_BANK = 4'hF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bank_load,
  input  logic [IMM_W-1:0]         bank_imm,
  output logic [IMM_W-1:0]         bank_sel,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_op,
  input  logic                     req_access,
  input  logic [OPND_W-1:0]        req_opnd,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [BANK_W+OPND_W-1:0] req_src,
  input  logic [BANK_W+OPND_W-1:0] req_dst,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_data,
  input  logic                     usb_en,
  input  logic                     usb_valid,
  input  logic                     usb_we,
  input  logic [OPND_W-1:0]        usb_addr,
  input  logic [DATA_W-1:0]        usb_wdata,
  output logic [DATA_W-1:0]        usb_rdata,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [BANK_W+OPND_W-1:0] mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic [DATA_W-1:0]        mem_rdata
);
  localparam int AW = BANK_W + OPND_W;

  op_e               op;
  state_e            st_q;
  logic              accept;
  logic              a_rd;
  logic              a_wr;
  logic              phase_b;
  logic [BANK_W-1:0] bank;
  logic [AW-1:0]     addr_a;
  tgt_e              tgt_a;
  tgt_e              tgt_b;
  tgt_e              src_tgt_q;
  logic [AW-1:0]     dst_q;
  logic              rd_pend_q;
  logic [DATA_W-1:0] buf_rdata;
  logic [DATA_W-1:0] rd_data;
  logic              core_buf_en;
  logic              core_buf_we;
  logic [OPND_W-1:0] core_buf_addr;
  logic [DATA_W-1:0] core_buf_wdata;

  assign op        = op_e'(req_op);
  assign phase_b   = (st_q == ST_MOVE_WR);
  assign req_ready = !phase_b;
  assign accept    = req_valid && req_ready;
  assign a_rd      = accept && (op == OP_READ || op == OP_MOVE);
  assign a_wr      = accept && (op == OP_WRITE);

  bdm_bank_reg #(
    .BANK_W (BANK_W),
    .IMM_W  (IMM_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (bank_load),
    .imm     (bank_imm),
    .bank    (bank),
    .bank_rd (bank_sel)
  );

  bdm_addr_gen #(
    .OPND_W      (OPND_W),
    .BANK_W      (BANK_W),
    .ACC_SPLIT   (ACC_SPLIT),
    .ACC_LO_BANK (ACC_LO_BANK),
    .ACC_HI_BANK (ACC_HI_BANK)
  ) u_agen (
    .full_en   (op == OP_MOVE),
    .full_addr (req_src),
    .access    (req_access),
    .opnd      (req_opnd),
    .bank      (bank),
    .addr      (addr_a)
  );

  // One decoder for the issue phase, one for the move write phase.
  bdm_region_dec #(
    .OPND_W    (OPND_W),
    .BANK_W    (BANK_W),
    .IMPL_MASK (IMPL_MASK),
    .BUF_BANK  (BUF_BANK)
  ) u_dec_a (
    .addr   (addr_a),
    .usb_en (usb_en),
    .tgt    (tgt_a)
  );

  bdm_region_dec #(
    .OPND_W    (OPND_W),
    .BANK_W    (BANK_W),
    .IMPL_MASK (IMPL_MASK),
    .BUF_BANK  (BUF_BANK)
  ) u_dec_b (
    .addr   (dst_q),
    .usb_en (usb_en),
    .tgt    (tgt_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rd_pend_q <= 1'b0;
      src_tgt_q <= TG_NONE;
      dst_q     <= '0;
    end else begin
      st_q      <= (accept && op == OP_MOVE) ? ST_MOVE_WR : ST_IDLE;
      rd_pend_q <= accept && (op == OP_READ);
      if (a_rd) begin
        src_tgt_q <= tgt_a;
      end
      if (accept && op == OP_MOVE) begin
        dst_q <= req_dst;
      end
    end
  end

  // Data returned by the storage that was read in the previous cycle.
  always_comb begin
    case (src_tgt_q)
      TG_MEM:  rd_data = mem_rdata;
      TG_BUF:  rd_data = buf_rdata;
      default: rd_data = '0;
    endcase
  end

  assign rsp_valid = rd_pend_q;
  assign rsp_data  = rd_data;

  always_comb begin
    if (phase_b) begin
      mem_req   = (tgt_b == TG_MEM);
      mem_we    = 1'b1;
      mem_addr  = dst_q;
      mem_wdata = rd_data;
    end else begin
      mem_req   = (a_rd || a_wr) && (tgt_a == TG_MEM);
      mem_we    = a_wr;
      mem_addr  = addr_a;
      mem_wdata = req_wdata;
    end
  end

  always_comb begin
    if (phase_b) begin
      core_buf_en    = (tgt_b == TG_BUF);
      core_buf_we    = core_buf_en;
      core_buf_addr  = dst_q[OPND_W-1:0];
      core_buf_wdata = rd_data;
    end else begin
      core_buf_en    = (a_rd || a_wr) && (tgt_a == TG_BUF);
      core_buf_we    = core_buf_en && a_wr;
      core_buf_addr  = addr_a[OPND_W-1:0];
      core_buf_wdata = req_wdata;
    end
  end

  bdm_buf_ram #(
    .DATA_W (DATA_W),
    .ADDR_W (OPND_W)
  ) u_buf (
    .clk        (clk),
    .usb_en     (usb_en),
    .usb_valid  (usb_valid),
    .usb_we     (usb_we),
    .usb_addr   (usb_addr),
    .usb_wdata  (usb_wdata),
    .core_en    (core_buf_en),
    .core_we    (core_buf_we),
    .core_addr  (core_buf_addr),
    .core_wdata (core_buf_wdata),
    .rdata      (buf_rdata)
  );

  assign usb_rdata = buf_rdata;
endmodule

// File: rtl/bdm_checker.sv
`timescale 1ns/1ps
module bdm_checker #(
  parameter int                     OPND_W    = 8,
  parameter int                     BANK_W    = 4,
  parameter int                     IMM_W     = 8,
  parameter logic [(1<<BANK_W)-1:0] IMPL_MASK = 16'h8007,
  parameter int                     BUF_BANK  = 4,
  parameter logic [OPND_W-1:0]      ACC_SPLIT = 8'h60
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bank_load,
  input logic [IMM_W-1:0]         bank_imm,
  input logic [IMM_W-1:0]         bank_sel,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [1:0]               req_op,
  input logic                     req_access,
  input logic [OPND_W-1:0]        req_opnd,
  input logic                     rsp_valid,
  input logic                     mem_req,
  input logic [BANK_W+OPND_W-1:0] mem_addr,
  input logic                     usb_en,
  input logic                     core_buf_we
);
  localparam int AW = BANK_W + OPND_W;

  logic          acc;
  logic          mem_bank_ok;
  logic [AW-1:0] win_addr;
  logic [BANK_W-1:0] mbk;

  assign acc         = req_valid && req_ready;
  assign mbk         = mem_addr[AW-1:OPND_W];
  assign mem_bank_ok = IMPL_MASK[mbk] && (int'(mbk) != BUF_BANK);
  assign win_addr    = (req_opnd < ACC_SPLIT) ? {{BANK_W{1'b0}}, req_opnd}
                                              : {{BANK_W{1'b1}}, req_opnd};

  AST_BANK_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel[IMM_W-1:BANK_W] == '0); // R2

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bank_load |=> bank_sel[BANK_W-1:0] == $past(bank_imm[BANK_W-1:0])); // R2

  AST_WINDOW_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_op[1] && req_access && mem_req) |-> mem_addr == win_addr); // R4

  AST_MEM_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_bank_ok); // R5

  AST_RSP_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc && req_op == 2'd0)); // R6

  AST_MOVE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'd2) |=> !req_ready); // R8

  AST_USB_OWNS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    usb_en |-> !core_buf_we); // R10

  AST_NOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'd3) |-> !mem_req); // R11
endmodule

bind banked_dmem_unit bdm_checker #(
  .OPND_W    (OPND_W),
  .BANK_W    (BANK_W),
  .IMM_W     (IMM_W),
  .IMPL_MASK (IMPL_MASK),
  .BUF_BANK  (BUF_BANK),
  .ACC_SPLIT (ACC_SPLIT)
) u_bdm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .bank_load   (bank_load),
  .bank_imm    (bank_imm),
  .bank_sel    (bank_sel),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_op      (req_op),
  .req_access  (req_access),
  .req_opnd    (req_opnd),
  .rsp_valid   (rsp_valid),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .usb_en      (usb_en),
  .core_buf_we (core_buf_we)
);

// File: tb/test_banked_dmem_unit.sv
`timescale 1ns/1ps
module test_banked_dmem_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_load = 1'b0;
  logic [7:0]  bank_imm = '0;
  logic [7:0]  bank_sel;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic        req_access = 1'b0;
  logic [7:0]  req_opnd = '0;
  logic [7:0]  req_wdata = '0;
  logic [11:0] req_src = '0;
  logic [11:0] req_dst = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        usb_en = 1'b0;
  logic        usb_valid = 1'b0;
  logic        usb_we = 1'b0;
  logic [7:0]  usb_addr = '0;
  logic [7:0]  usb_wdata = '0;
  logic [7:0]  usb_rdata;
  logic        mem_req;
  logic        mem_we;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] ram        [4096];
  logic [7:0] shadow_ext [4096];
  logic [7:0] shadow_buf [256];
  logic [3:0] bk_m = '0;
  bit         usb_en_r = 1'b0;

  always #2.5 clk = ~clk;

  banked_dmem_unit i_banked_dmem_unit (
    .clk(clk), .rst_n(rst_n), .bank_load(bank_load), .bank_imm(bank_imm),
    .bank_sel(bank_sel), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_access(req_access), .req_opnd(req_opnd),
    .req_wdata(req_wdata), .req_src(req_src), .req_dst(req_dst),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .usb_en(usb_en),
    .usb_valid(usb_valid), .usb_we(usb_we), .usb_addr(usb_addr),
    .usb_wdata(usb_wdata), .usb_rdata(usb_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [11:0] f_addr(bit acc, logic [7:0] opnd, logic [3:0] bk);
    if (acc) return (opnd < 8'h60) ? {4'h0, opnd} : {4'hF, opnd};
    return {bk, opnd};
  endfunction

  // 0 = unimplemented or blocked, 1 = external RAM, 2 = buffer
  function automatic int f_cls(logic [11:0] a, bit ue);
    logic [3:0] b = a[11:8];
    if (b == 4'd4) return ue ? 0 : 2;
    if (b <= 4'd2 || b == 4'hF) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] f_val(logic [11:0] a, bit ue);
    case (f_cls(a, ue))
      1:       return shadow_ext[a];
      2:       return shadow_buf[a[7:0]];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic put(logic [11:0] a, logic [7:0] d, bit ue);
    case (f_cls(a, ue))
      1:       shadow_ext[a] = d;
      2:       shadow_buf[a[7:0]] = d;
      default: ;
    endcase
  endtask

  // External RAM model with one cycle of read latency, plus a port monitor.
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata     <= ram[mem_addr];
    end
    if (rst_n && mem_req) begin
      checks++;
      if (f_cls(mem_addr, 1'b0) != 1) begin
        fails++;
        $display("FAIL R5 mem_req to unbacked addr actual=0x%0h expected=backed bank", mem_addr);
      end
    end
  end

  task automatic core_op(logic [1:0] op, bit acc, logic [7:0] opnd, logic [7:0] wd,
                         logic [11:0] src, logic [11:0] dst, string r);
    logic [11:0] a;
    logic [7:0]  ev;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_access = acc; req_opnd = opnd;
    req_wdata = wd; req_src = src; req_dst = dst;
    while (!req_ready) @(negedge clk);
    a  = (op == 2'd2) ? src : f_addr(acc, opnd, bk_m);
    ev = f_val(a, usb_en_r);
    if (op == 2'd3) chk(mem_req == 1'b0, "R11", mem_req, 0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    case (op)
      2'd0: chk(rsp_valid && rsp_data == ev, r, {rsp_valid, rsp_data}, {1'b1, ev});
      2'd1: begin
        chk(!rsp_valid, r, rsp_valid, 0);
        put(a, wd, usb_en_r);
      end
      2'd2: begin
        chk(!req_ready && !rsp_valid, "R8", {req_ready, rsp_valid}, 0);
        put(dst, ev, usb_en_r);
      end
      default: chk(!rsp_valid, "R11", rsp_valid, 0);
    endcase
  endtask

  task automatic rd(bit acc, logic [7:0] opnd, string r);
    core_op(2'd0, acc, opnd, 8'h00, 12'h000, 12'h000, r);
  endtask

  task automatic wr(bit acc, logic [7:0] opnd, logic [7:0] d, string r);
    core_op(2'd1, acc, opnd, d, 12'h000, 12'h000, r);
  endtask

  task automatic mv(logic [11:0] s, logic [11:0] d, string r);
    core_op(2'd2, 1'b0, 8'h00, 8'h00, s, d, r);
  endtask

  task automatic bank_ld(logic [7:0] imm);
    @(negedge clk);
    bank_load = 1'b1; bank_imm = imm;
    @(posedge clk);
    @(negedge clk);
    bank_load = 1'b0;
    bk_m = imm[3:0];
    chk(bank_sel == {4'h0, imm[3:0]}, "R2", bank_sel, {4'h0, imm[3:0]});
  endtask

  task automatic set_usb(bit v);
    @(negedge clk);
    usb_en = v; usb_en_r = v;
  endtask

  task automatic usb_op(bit we, logic [7:0] a, logic [7:0] d, bit check);
    @(negedge clk);
    usb_valid = 1'b1; usb_we = we; usb_addr = a; usb_wdata = d;
    @(posedge clk);
    @(negedge clk);
    usb_valid = 1'b0;
    if (usb_en_r) begin
      if (we) shadow_buf[a] = d;
      else if (check) chk(usb_rdata == shadow_buf[a], "R10", usb_rdata, shadow_buf[a]);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) begin
      ram[i] = 8'h00; shadow_ext[i] = 8'h00;
    end
    for (int i = 0; i < 256; i++) shadow_buf[i] = 8'h00;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bank_sel == 8'h00 && req_ready && !rsp_valid && !mem_req, "R1",
        {bank_sel, req_ready, rsp_valid, mem_req}, 12'h004);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bank_sel == 8'h00 && req_ready && !rsp_valid, "R1",
        {bank_sel, req_ready, rsp_valid}, 10'h002);

    // Clear the buffer through the USB side.
    set_usb(1'b1);
    for (int i = 0; i < 256; i++) usb_op(1'b1, 8'(i), 8'h00, 1'b0);
    set_usb(1'b0);

    bank_ld(8'hF3);                       // R2: upper nibble discarded
    wr(1'b0, 8'h20, 8'hAB, "R5");         // bank 3 unimplemented, dropped
    rd(1'b0, 8'h20, "R5");                // reads 0x00
    bank_ld(8'h01);
    wr(1'b0, 8'h20, 8'h77, "R3");
    rd(1'b0, 8'h20, "R3");
    @(negedge clk);
    chk(!rsp_valid, "R6", rsp_valid, 0);  // single-cycle pulse

    bank_ld(8'h00);
    wr(1'b0, 8'h50, 8'h11, "R4");
    bank_ld(8'h0F);
    wr(1'b0, 8'h80, 8'h99, "R4");
    bank_ld(8'h07);                       // window ignores the bank register
    rd(1'b1, 8'h50, "R4");
    rd(1'b1, 8'h80, "R4");
    rd(1'b1, 8'h5F, "R4");
    rd(1'b1, 8'h60, "R4");

    mv(12'h120, 12'h2FF, "R7");
    bank_ld(8'h02);
    rd(1'b0, 8'hFF, "R7");
    mv(12'h520, 12'h2FF, "R7");           // unimplemented source gives 0
    rd(1'b0, 8'hFF, "R7");
    mv(12'h050, 12'h7AA, "R7");           // unimplemented destination dropped

    // R8: a read held during the move write cycle waits one cycle.
    mv(12'h050, 12'h2F0, "R8");
    req_valid = 1'b1; req_op = 2'd0; req_access = 1'b0; req_opnd = 8'hF0;
    @(posedge clk);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R8", {rsp_valid, req_ready}, 2'b01);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_data == 8'h11, "R8", rsp_data, 8'h11);

    core_op(2'd3, 1'b0, 8'h20, 8'hEE, 12'h000, 12'h000, "R11");

    // Bank 4 as plain storage, USB port ignored.
    bank_ld(8'h04);
    wr(1'b0, 8'h10, 8'h55, "R9");
    rd(1'b0, 8'h10, "R9");
    usb_op(1'b1, 8'h10, 8'hC3, 1'b0);
    rd(1'b0, 8'h10, "R9");

    // USB owns the buffer.
    set_usb(1'b1);
    rd(1'b0, 8'h10, "R10");
    wr(1'b0, 8'h10, 8'h66, "R10");
    usb_op(1'b0, 8'h10, 8'h00, 1'b1);
    @(negedge clk);                       // simultaneous core and USB write
    req_valid = 1'b1; req_op = 2'd1; req_access = 1'b0; req_opnd = 8'h30; req_wdata = 8'h3C;
    usb_valid = 1'b1; usb_we = 1'b1; usb_addr = 8'h30; usb_wdata = 8'hA5;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; usb_valid = 1'b0;
    shadow_buf[8'h30] = 8'hA5;
    usb_op(1'b0, 8'h30, 8'h00, 1'b1);
    mv(12'h050, 12'h431, "R10");          // move into owned buffer dropped
    usb_op(1'b0, 8'h31, 8'h00, 1'b1);
    set_usb(1'b0);
    rd(1'b0, 8'h30, "R10");               // core sees USB data

    // R12: request in the same cycle as a bank load uses the old bank.
    bank_ld(8'h01);
    @(negedge clk);
    bank_load = 1'b1; bank_imm = 8'h02;
    req_valid = 1'b1; req_op = 2'd0; req_access = 1'b0; req_opnd = 8'h20;
    @(posedge clk);
    @(negedge clk);
    bank_load = 1'b0; req_valid = 1'b0; bk_m = 4'h2;
    chk(rsp_valid && rsp_data == 8'h77, "R12", rsp_data, 8'h77);

    // Constrained random mix.
    for (int it = 0; it < 600; it++) begin
      int sel = $urandom_range(0, 9);
      logic [7:0] o = 8'($urandom);
      logic [7:0] d = 8'($urandom);
      logic [11:0] s = 12'($urandom);
      logic [11:0] t = 12'($urandom);
      case (sel)
        0:       bank_ld(8'($urandom));
        1, 2:    rd(1'($urandom), o, "R5");
        3, 4:    wr(1'($urandom), o, d, "R3");
        5:       mv(s, t, "R7");
        6:       core_op(2'd3, 1'b0, o, d, s, t, "R11");
        7:       usb_op(1'($urandom), o, d, 1'b1);
        8:       set_usb(1'($urandom));
        default: rd(1'b0, o, "R9");
      endcase
    end
    set_usb(1'b0);
    for (int i = 0; i < 16; i++) begin
      bank_ld(8'h04);
      rd(1'b0, 8'(i * 16), "R9");
    end

    summary();
  end
endmodule